// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block collects up to 96 level-sensitive peripheral interrupt sources, grouped into banks of 32, and drives them onto two processor lines: a normal interrupt line (IRQ) and a fast interrupt line (FIQ). Each bank has three kinds of register. The mask enables sources. The route selects which line a source drives. The pending views are read-only and show the raw levels, and the levels after masking for each line.

Software reaches every register through a simple 32-bit word-addressed read/write port. A control bit decides whether any pending source wakes the core from idle, or only an unmasked one. A programmable priority table gives each slot a source number and a valid flag. A lower slot number has higher precedence. A registered search over the table produces a highest-priority register. That register reports a valid flag and the index of the winning source, which is a source that is both pending and unmasked.

Top module: `banked_intc`

## Requirements
- R1: After reset, every mask, route, control and priority entry reads 0, the highest-priority register reads 0, and irq_o and fiq_o are low.
- R2: A read presented with re_i at a rising edge appears on rdata_o after that edge, and rdata_o holds its value in every cycle where re_i was low at the previous edge.
- R3: Bank b's registers sit at base 0x000, 0x09C or 0x130 for b = 0, 1, 2. The offsets from the base are: masked IRQ pending 0x00, mask 0x04, route 0x08, masked FIQ pending 0x0C, raw pending 0x10. Bit n of a bank word maps to source 32*b+n.
- R4: Mask bit 1 enables a source. Route bit 0 sends the source to IRQ and route bit 1 sends it to FIQ. The IRQ pending word equals raw & mask & ~route, and the FIQ pending word equals raw & mask & route.
- R5: irq_o is the OR of all IRQ pending bits over all banks, and fiq_o is the OR of all FIQ pending bits. Both follow the inputs without a register.
- R6: The control register is at 0x014, and only bit 0 is kept. With bit 0 set, wake_o is the OR of the unmasked raw pending bits. With bit 0 clear, wake_o is the OR of all raw pending bits.
- R7: Priority slot i is at 0x01C+4i for i<32, at 0x0B0+4(i-32) for i<64, and at 0x144+4(i-64) otherwise. Bit 31 of a slot is its valid flag, and bits 6:0 hold the source number. Those fields read back, and every other bit reads 0.
- R8: The highest-priority register is at 0x018. Bit 31 is set when some valid slot names a source that is pending and unmasked. Bits 30:16 then give the source of the lowest-numbered such slot. Routing does not affect the search. The register updates one edge after its inputs change and reads 0 when nothing qualifies.
- R9: Writes to the pending words, to the highest-priority register and to unmapped or misaligned addresses leave all state unchanged. Reads of unmapped addresses return 0.
- R10: A slot whose source number is 96 or above never wins the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive source requests |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address of a 32-bit register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Wake-from-idle request |

## Verification
The bench builds the block with the default of 96 sources. This makes all three banks present, and with them both irregular gaps in the address map and the priority slots at 0x144 onward. Sources are placed in every bank. Entries are written into the first, middle and last priority slots, so the search is exercised across bank boundaries: a higher slot can win only after the lower ones drop out, and a routed-to-FIQ source can still win. An out-of-range source number and writes aimed at read-only or unmapped words are checked against the readback of the state they could have disturbed.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BANK_W = 32;

  localparam logic [ADDR_W-1:0] OFF_IRQ   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_ROUTE = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_FIQ   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_HP    = 12'h018;

  // irregular spacing is part of the register map
  function automatic logic [ADDR_W-1:0] bank_base(input int unsigned b);
    case (b)
      0:       return 12'h000;
      1:       return 12'h09C;
      default: return 12'h130;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] prio_base(input int unsigned b);
    case (b)
      0:       return 12'h01C;
      1:       return 12'h0B0;
      default: return 12'h144;
    endcase
  endfunction
endpackage

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] raw_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_data_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] route_o,
  output logic [BANK_W-1:0] irq_pend_o,
  output logic [BANK_W-1:0] fiq_pend_o
);
  localparam logic [ADDR_W-1:0] A_IRQ   = BASE + OFF_IRQ;
  localparam logic [ADDR_W-1:0] A_MASK  = BASE + OFF_MASK;
  localparam logic [ADDR_W-1:0] A_ROUTE = BASE + OFF_ROUTE;
  localparam logic [ADDR_W-1:0] A_FIQ   = BASE + OFF_FIQ;
  localparam logic [ADDR_W-1:0] A_RAW   = BASE + OFF_RAW;

  logic [BANK_W-1:0] mask_q, route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_MASK)  mask_q  <= wdata_i[BANK_W-1:0];
      if (addr_i == A_ROUTE) route_q <= wdata_i[BANK_W-1:0];
    end
  end

  assign irq_pend_o = raw_i & mask_q & ~route_q;
  assign fiq_pend_o = raw_i & mask_q & route_q;
  assign mask_o     = mask_q;
  assign route_o    = route_q;

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_IRQ)   rd_data_o = irq_pend_o;
    if (addr_i == A_MASK)  rd_data_o = mask_q;
    if (addr_i == A_ROUTE) rd_data_o = route_q;
    if (addr_i == A_FIQ)   rd_data_o = fiq_pend_o;
    if (addr_i == A_RAW)   rd_data_o = raw_i;
  end
endmodule

// File: rtl/icu_prio_table.sv
module icu_prio_table
  import icu_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 96,
  parameter int unsigned IDX_W     = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rd_data_o,
  output logic                 hp_valid_o,
  output logic [IDX_W-1:0]     hp_src_o
);
  localparam int unsigned PAD = 1 << IDX_W;

  logic [NUM_SLOTS-1:0] vld_q;
  logic [IDX_W-1:0]     src_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_hit;

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A =
      prio_base(j / BANK_W) + ADDR_W'((j % BANK_W) * 4);
    assign slot_hit[j] = (addr_i == SLOT_A);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[j] <= 1'b0;
        src_q[j] <= '0;
      end else if (we_i && slot_hit[j]) begin
        vld_q[j] <= wdata_i[31];
        src_q[j] <= wdata_i[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int j = 0; j < NUM_SLOTS; j++)
      if (slot_hit[j]) rd_data_o = {vld_q[j], {(31-IDX_W){1'b0}}, src_q[j]};
  end

  // zero padding keeps out-of-range source numbers from matching
  logic [PAD-1:0]   pend_pad;
  logic             win;
  logic [IDX_W-1:0] win_src;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_SLOTS-1:0] = pend_i;
    win     = 1'b0;
    win_src = '0;
    for (int j = NUM_SLOTS - 1; j >= 0; j--) begin
      if (vld_q[j] && pend_pad[src_q[j]]) begin
        win     = 1'b1;
        win_src = src_q[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_valid_o <= 1'b0;
      hp_src_o   <= '0;
    end else begin
      hp_valid_o <= win;
      hp_src_o   <= win_src;
    end
  end
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import icu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int unsigned NUM_BANKS = NUM_SRC / BANK_W;
  localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] mask_all, route_all, irq_pend_all, fiq_pend_all;
  logic [31:0]        bank_rd [NUM_BANKS];
  logic [31:0]        prio_rd;
  logic               ctrl_q;
  logic               hp_valid;
  logic [IDX_W-1:0]   hp_src;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    icu_bank #(.BASE(bank_base(b))) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .raw_i      (src_i[b*BANK_W +: BANK_W]),
      .we_i       (we_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rd_data_o  (bank_rd[b]),
      .mask_o     (mask_all[b*BANK_W +: BANK_W]),
      .route_o    (route_all[b*BANK_W +: BANK_W]),
      .irq_pend_o (irq_pend_all[b*BANK_W +: BANK_W]),
      .fiq_pend_o (fiq_pend_all[b*BANK_W +: BANK_W])
    );
  end

  icu_prio_table #(.NUM_SLOTS(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (src_i & mask_all),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rd_data_o  (prio_rd),
    .hp_valid_o (hp_valid),
    .hp_src_o   (hp_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ctrl_q <= 1'b0;
    else if (we_i && addr_i == OFF_CTRL)    ctrl_q <= wdata_i[0];
  end

  assign irq_o  = |irq_pend_all;
  assign fiq_o  = |fiq_pend_all;
  assign wake_o = ctrl_q ? |(src_i & mask_all) : |src_i;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = prio_rd;
    for (int b = 0; b < NUM_BANKS; b++) rd_val = rd_val | bank_rd[b];
    if (addr_i == OFF_CTRL) rd_val = {31'b0, ctrl_q};
    if (addr_i == OFF_HP)   rd_val = {hp_valid, 15'(hp_src), 16'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk #(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned IDX_W   = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               re_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               wake_o,
  input logic [NUM_SRC-1:0] mask_all,
  input logic               ctrl_q,
  input logic               hp_valid,
  input logic [IDX_W-1:0]   hp_src
);
  a_r4_all_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_all == '0) |-> (!irq_o && !fiq_o));

  a_r6_wake_on_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q && (|src_i)) |-> wake_o);

  a_r6_no_wake_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> !wake_o);

  a_r8_hp_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_valid |-> $past(|(src_i & mask_all)));

  a_r10_hp_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_valid |-> (32'(hp_src) < NUM_SRC));

  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind banked_intc banked_intc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .wake_o   (wake_o),
  .mask_all (mask_all),
  .ctrl_q   (ctrl_q),
  .hp_valid (hp_valid),
  .hp_src   (hp_src)
);

// File: tb/sim_banked_intc.sv
`timescale 1ns/1ps
module sim_banked_intc;
  localparam int unsigned N = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq, wake;

  int checks = 0, errors = 0;
  bit done = 0, rd_fly = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  banked_intc #(.NUM_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; re = 1'b1; rd_fly = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0; rd_fly = 0;
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(negedge clk); src = v; #1;
  endtask

  // monitor: compares read data one edge after the request
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rd_fly) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] s;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    chk("R1 irq_o", irq, 0);
    chk("R1 fiq_o", fiq, 0);
    rd(12'h004, 0, "R1 mask0");
    rd(12'h008, 0, "R1 route0");
    rd(12'h014, 0, "R1 ctrl");
    rd(12'h018, 0, "R1 hp");
    rd(12'h01C, 0, "R1 slot0");
    rd(12'h1C0, 0, "R1 slot95");

    // R6 wake on raw with control clear, R3 raw word
    s = '0; s[5] = 1'b1; set_src(s);
    chk("R6 wake raw", wake, 1);
    chk("R4 masked irq_o", irq, 0);
    rd(12'h010, 32'h20, "R3 raw0");
    rd(12'h000, 32'h0, "R4 irq pend masked");
    wr(12'h014, 32'h1);
    chk("R6 wake needs unmask", wake, 0);

    // R4 R5 unmask and route
    wr(12'h004, 32'h20);
    chk("R5 irq_o", irq, 1);
    chk("R6 wake unmasked", wake, 1);
    rd(12'h000, 32'h20, "R4 irq pend0");
    rd(12'h00C, 32'h0, "R4 fiq pend0 empty");
    wr(12'h008, 32'h20);
    chk("R5 fiq_o", fiq, 1);
    chk("R5 irq_o off", irq, 0);
    rd(12'h00C, 32'h20, "R4 fiq pend0");

    // R3 bank 1 and bank 2
    s[40] = 1'b1; set_src(s);
    rd(12'h0AC, 32'h100, "R3 raw1");
    wr(12'h0A0, 32'h100);
    rd(12'h09C, 32'h100, "R3 irq pend1");
    chk("R5 irq_o bank1", irq, 1);
    s[70] = 1'b1; set_src(s);
    rd(12'h140, 32'h40, "R3 raw2");
    wr(12'h134, 32'h40);
    wr(12'h138, 32'h40);
    rd(12'h13C, 32'h40, "R3 fiq pend2");
    rd(12'h130, 32'h0, "R3 irq pend2");

    // R7 R8 priority table
    wr(12'h01C, 32'h8000_0046);
    wr(12'h020, 32'h8000_0005);
    idle(1);
    rd(12'h018, 32'h8046_0000, "R8 slot0 wins fiq-routed");
    rd(12'h01C, 32'h8000_0046, "R7 slot0 readback");
    wr(12'h134, 32'h0);
    idle(1);
    rd(12'h018, 32'h8005_0000, "R8 slot1 after mask");
    wr(12'h0D0, 32'h8001_2345);
    rd(12'h0D0, 32'h8000_0045, "R7 slot40 field trim");
    wr(12'h01C, 32'h0);
    wr(12'h1C0, 32'h8000_0028);
    idle(1);
    rd(12'h018, 32'h8005_0000, "R8 lower slot first");
    rd(12'h01C, 32'h0, "R7 slot0 invalid");
    s[5] = 1'b0; set_src(s);
    idle(1);
    rd(12'h018, 32'h8028_0000, "R8 last slot wins");

    // R10 out-of-range source
    wr(12'h024, 32'h8000_0064);
    idle(1);
    rd(12'h018, 32'h8028_0000, "R10 out-of-range ignored");
    rd(12'h024, 32'h8000_0064, "R7 slot2 readback");

    set_src('0);
    idle(1);
    rd(12'h018, 32'h0, "R8 none pending");
    chk("R5 irq_o idle", irq, 0);

    // R9 ignored writes
    s = '0; s[5] = 1'b1; set_src(s);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h20, "R9 raw read-only");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h004, 32'h20, "R9 pend write no mask change");
    wr(12'h018, 32'h0);
    idle(1);
    rd(12'h018, 32'h8005_0000, "R9 hp read-only");
    wr(12'h006, 32'hFFFF_FFFF);
    rd(12'h004, 32'h20, "R9 misaligned write");
    wr(12'h1C4, 32'hFFFF_FFFF);
    rd(12'h1C4, 32'h0, "R9 unmapped read");
    rd(12'h200, 32'h0, "R9 unmapped far");
    rd(12'h008, 32'h20, "R9 route unchanged");

    // R2 hold without read
    rd(12'h004, 32'h20, "R2 last read");
    idle(3);
    chk("R2 rdata hold", rdata, 32'h20);

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule